// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block gathers up to eight asynchronous event lines behind one byte-wide register and turns them into a single level interrupt. Each line is brought into the clock domain by a short flop chain. A rising edge on a line is remembered in a status bit, but only when that source is enabled. Software sees all of this through one address. A write loads the enable mask. A read returns the latched status of the enabled sources, limited to the set of sources that exist in this instance.

The block has no separate acknowledge register. Writing the enable mask with a bit at 0 masks that source and also wipes its latched status. A handler therefore reads the status and writes the mask with the seen bits cleared, which removes the interrupt cause. It then writes the full mask again to re-arm those sources. Writing zero turns every source off, and is what software does at start-up and when it stops.

The interrupt output is a registered OR of all enabled status bits. It stays high as long as any such bit is set.

Top module: `irq_src_reg`

## Requirements
- R1: After a synchronous active-low reset, the enable mask and all status bits are 0, irq_o is 0 and a read of the register returns 0.
- R2: The register answers only at address 0x1E (5-bit address). A write to any other address changes neither the mask nor the status. A read at any other address returns 0.
- R3: A write to the register loads the enable mask with wr_data_i ANDed with VALID_MASK. Bit n of the data enables source n.
- R4: A 0-to-1 change on evt_i[n] sets status bit n at the third rising clock edge after the change, provided enable bit n is 1. A line held high sets the status only once; a new rise is needed for a new event.
- R5: An input rise that happens while its enable bit is 0 is discarded. Enabling the source later does not make that event appear.
- R6: A read returns the status bits ANDed with VALID_MASK. Bits outside VALID_MASK always read 0 and never raise irq_o.
- R7: A write that leaves enable bit n at 0 clears status bit n at the same clock edge. A read right after the write shows bit n as 0.
- R8: irq_o is registered. It rises one clock after any enabled status bit becomes set, and falls one clock after the last such bit is cleared.
- R9: Writing a previously cleared enable bit back to 1 re-arms that source: the old event does not come back, and a new rise sets the status again.
- R10: An edge that would be latched at the same clock edge as a register write is judged against the mask held before the write. If the write clears the bit, the event is lost. If the write sets a bit that was 0, the event is lost as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NUM_SRC | Asynchronous event lines, one per source |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | NUM_SRC | Write data: the new enable mask |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | NUM_SRC | Read data: valid latched status; 0 when no read hits |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can fall on the same clock edge: the latching of a synchronised input edge and a software write to the enable mask. The bench forces this overlap by raising the event lines and counting two falling clock edges before it issues the write, so that the detected edge and the write meet at one rising clock edge. It then judges the outcome by reading the register. A source whose bit the write cleared must read 0. A source the write kept enabled must read 1. A source the write newly enabled must read 0, because the mask held before the write decides.

// File: rtl/irq_src_pkg.sv
// Package irq_src_pkg
// Shared defaults and a helper for the interrupt source register.
// Assumes addresses are byte offsets compared on the full address width.
package irq_src_pkg;

    localparam int DEF_NUM_SRC     = 8;
    localparam int DEF_ADDR_W      = 5;
    localparam int DEF_SYNC_STAGES = 2;

    // True when an access address selects the register offset.
    function automatic logic addr_hit(input logic [31:0] addr, input logic [31:0] offset);
        return addr == offset;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
// Module irq_edge_sync
// Brings each asynchronous event line into the clock domain through
// SYNC_STAGES flops. It then emits a one-cycle pulse on each
// synchronised 0-to-1 change.
// Assumes SYNC_STAGES >= 2 and event pulses longer than a clock period.
module irq_edge_sync #(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] rise_o
);

    localparam int LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain_q;
        logic                   prev_q;

        // Shift the raw line through the synchroniser and keep the last value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], evt_i[g]};
                prev_q  <= chain_q[LAST];
            end
        end

        // Rising edge of the synchronised line.
        always_comb begin
            rise_o[g] = chain_q[LAST] & ~prev_q;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
// Module irq_status_bank
// Holds the enable mask and the latched status bits.
// A detected edge sets a status bit only if the enable bit was already 1
// before this edge. A write loads the mask, and the same edge clears the
// status of every source whose new enable bit is 0.
// Assumes wr_hit_i is a one-cycle strobe already decoded for the register.
module irq_status_bank #(
    parameter int                 NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               wr_hit_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] status_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] keep_mask;
    logic [NUM_SRC-1:0] status_d;

    // Mask applied to status this cycle: the new enables on a write, else all ones.
    always_comb begin
        keep_mask = wr_hit_i ? wr_data_i : '1;
    end

    // Next status: add edges of enabled sources, then drop any source being disabled.
    always_comb begin
        status_d = (status_q | (rise_i & en_q)) & keep_mask & VALID_MASK;
    end

    // Enable mask register, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit_i) begin
            en_q <= wr_data_i & VALID_MASK;
        end
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign en_o     = en_q;
    assign status_o = status_q;

    // R5
    status_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

    // R7
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_i |=> ((status_q & ~$past(wr_data_i)) == '0));

    // R6
    status_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~VALID_MASK) == '0));

endmodule

// File: rtl/irq_req_gen.sv
// Module irq_req_gen
// Registers the OR of all enabled status bits into the interrupt line.
// Assumes status and enable come from registers in the same clock domain.
module irq_req_gen #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               irq_o
);

    logic active;
    logic irq_q;

    // Any enabled source pending.
    always_comb begin
        active = |(status_i & en_i);
    end

    // Interrupt line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= active;
        end
    end

    assign irq_o = irq_q;

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(active));

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> !$past(active));

endmodule

// File: rtl/irq_src_reg.sv
// Module irq_src_reg
// Top level of the interrupt source register. It decodes byte accesses at
// REG_OFFSET, loads the enable mask on writes, returns valid enabled status
// on reads, and drives a registered level interrupt.
// Assumes strobes are single-cycle and synchronous to clk.
module irq_src_reg
    import irq_src_pkg::*;
#(
    parameter int                 NUM_SRC     = DEF_NUM_SRC,
    parameter int                 ADDR_W      = DEF_ADDR_W,
    parameter int                 SYNC_STAGES = DEF_SYNC_STAGES,
    parameter logic [ADDR_W-1:0]  REG_OFFSET  = 5'h1E,
    parameter logic [NUM_SRC-1:0] VALID_MASK  = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               rd_en_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_o
);

    logic               sel;
    logic               wr_hit;
    logic               rd_hit;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] status;

    // Address decode for the single register.
    always_comb begin
        sel    = addr_hit(32'(addr_i), 32'(REG_OFFSET));
        wr_hit = wr_en_i & sel;
        rd_hit = rd_en_i & sel;
    end

    irq_edge_sync #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .rise_o (rise)
    );

    irq_status_bank #(
        .NUM_SRC    (NUM_SRC),
        .VALID_MASK (VALID_MASK)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .wr_hit_i  (wr_hit),
        .wr_data_i (wr_data_i),
        .en_o      (en),
        .status_o  (status)
    );

    irq_req_gen #(
        .NUM_SRC (NUM_SRC)
    ) req_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .en_i     (en),
        .irq_o    (irq_o)
    );

    // Read path: valid enabled status on a hit, zero otherwise.
    always_comb begin
        rd_data_o = rd_hit ? (status & en & VALID_MASK) : '0;
    end

    // R2
    rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data_o == '0));

endmodule

// File: tb/irq_src_reg_tb.sv
// Bench irq_src_reg_tb_top
// Sweeps every source through the latch / clear / re-arm cycle. It also
// covers disabled, invalid, level-held and address-miss cases and write
// collisions. Inputs change on falling clock edges.
module irq_src_reg_tb_top;

    localparam int         N    = 8;
    localparam logic [4:0] OFF  = 5'h1E;
    localparam logic [7:0] VM   = 8'hB7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt;
    logic [4:0] addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_src_reg #(
        .NUM_SRC    (N),
        .ADDR_W     (5),
        .REG_OFFSET (OFF),
        .VALID_MASK (VM)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        #1;
        check(tag, rd_data, exp);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        evt = evt | m;
        tick(3);
        evt = evt & ~m;
        tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt = '0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd_chk(OFF, 8'h00, "R1 read after reset");
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        pulse(8'hFF);
        rd_chk(OFF, 8'h00, "R1 mask zero after reset");

        // R4 / R8 latency on source 0
        wr_reg(OFF, 8'hFF);
        evt = 8'h01;
        tick(2);
        rd_chk(OFF, 8'h00, "R4 not yet latched after two edges");
        tick(1);
        rd_chk(OFF, 8'h01, "R4 latched at third edge");
        check("R8 irq not yet high", {7'd0, irq}, 8'h00);
        tick(1);
        check("R8 irq high one clock later", {7'd0, irq}, 8'h01);
        evt = 8'h00;
        tick(3);
        wr_reg(OFF, 8'hFE);
        check("R8 irq still high at clear edge", {7'd0, irq}, 8'h01);
        tick(1);
        check("R8 irq low after clear", {7'd0, irq}, 8'h00);
        wr_reg(OFF, 8'h00);

        // R3 R6 R7 R9 sweep over every source
        for (int i = 0; i < N; i++) begin
            logic [7:0] bit_m;
            logic [7:0] exp;
            bit_m = 8'(1 << i);
            exp   = bit_m & VM;
            wr_reg(OFF, 8'hFF);
            pulse(bit_m);
            rd_chk(OFF, exp, "R3 R6 source latched");
            check("R8 irq follows source", {7'd0, irq}, {7'd0, exp != 0});
            wr_reg(OFF, ~bit_m);
            rd_chk(OFF, 8'h00, "R7 clear by enable write");
            tick(1);
            check("R8 irq cleared", {7'd0, irq}, 8'h00);
            wr_reg(OFF, 8'hFF);
            rd_chk(OFF, 8'h00, "R9 old event not restored");
            pulse(bit_m);
            rd_chk(OFF, exp, "R9 re-armed source latches again");
            wr_reg(OFF, 8'h00);
        end

        // R5 events while disabled are lost
        pulse(8'hFF);
        wr_reg(OFF, 8'hFF);
        rd_chk(OFF, 8'h00, "R5 disabled events discarded");
        tick(1);
        check("R5 irq stays low", {7'd0, irq}, 8'h00);

        // R6 invalid sources never report
        pulse(8'h48);
        rd_chk(OFF, 8'h00, "R6 invalid bits read zero");
        tick(1);
        check("R6 invalid bits no irq", {7'd0, irq}, 8'h00);

        // R4 level held high latches once
        evt = 8'h02;
        tick(4);
        rd_chk(OFF, 8'h02, "R4 level rise latched");
        wr_reg(OFF, 8'hFD);
        wr_reg(OFF, 8'hFF);
        tick(4);
        rd_chk(OFF, 8'h00, "R4 held level no new event");
        evt = 8'h00;
        tick(4);

        // R3 partial mask with several sources
        pulse(8'hA5);
        rd_chk(OFF, 8'hA5, "R3 multi-source latch");
        wr_reg(OFF, 8'h0F);
        rd_chk(OFF, 8'h05, "R3 partial mask keeps low bits");
        check("R8 irq with remaining bits", {7'd0, irq}, 8'h01);
        wr_reg(OFF, 8'h00);
        tick(1);
        check("R8 irq low after all cleared", {7'd0, irq}, 8'h00);

        // R2 address decode
        wr_reg(OFF, 8'hFF);
        pulse(8'h01);
        wr_reg(5'h1D, 8'h00);
        wr_reg(5'h1F, 8'h00);
        rd_chk(OFF, 8'h01, "R2 foreign write ignored");
        rd_chk(5'h1D, 8'h00, "R2 foreign read is zero");
        check("R2 irq kept", {7'd0, irq}, 8'h01);

        // R10 collision: edge meets a write at the same clock edge
        wr_reg(OFF, 8'h00);
        wr_reg(OFF, 8'hFF);
        evt = 8'h05;
        tick(2);
        wr_reg(OFF, 8'hFE);
        rd_chk(OFF, 8'h04, "R10 cleared bit drops same-edge event");
        evt = 8'h00;
        tick(4);
        wr_reg(OFF, 8'hFF);
        rd_chk(OFF, 8'h04, "R10 dropped event stays lost");
        wr_reg(OFF, 8'h00);
        evt = 8'h01;
        tick(2);
        wr_reg(OFF, 8'hFF);
        rd_chk(OFF, 8'h00, "R10 newly enabled bit misses same-edge event");
        evt = 8'h00;
        tick(4);
        rd_chk(OFF, 8'h00, "R10 no late latch");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule